// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Buffer

This block takes an asynchronous serial line and turns each frame into an 8-bit character. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line is sampled on a baud tick that runs at `OVS` times the bit rate. Received characters go into a four-entry first-in first-out buffer.

A small register port gives software access to the block. Address 0 returns the oldest buffered character, and a read strobe at that address pops it. Address 1 returns the status byte. The status byte holds a two-bit occupancy code and three sticky error flags: framing, parity and overrun. A flag is cleared by writing 0 to its bit. Writing 1 to a flag bit does nothing.

The receiver FSM has six states:
- `S_IDLE` waits for the line to go low, then moves to `S_START`.
- `S_START` checks the line at mid start bit. If the line is low it moves to `S_DATA`. If the line is high it was a false start and the FSM returns to `S_IDLE`.
- `S_DATA` samples eight bits. After the last one it moves to `S_PAR` when parity is enabled, otherwise to `S_STOP`.
- `S_PAR` samples the parity bit and moves to `S_STOP`.
- `S_STOP` samples the stop bit and hands the frame over. A high stop bit returns the FSM to `S_IDLE`. A low stop bit moves it to `S_HOLD`.
- `S_HOLD` waits for the line to go high and then returns to `S_IDLE`.

Top module: `serial_rx_status`

## Requirements
- R1: The buffer holds up to four characters and returns them in arrival order.
- R2: Status bits [1:0] hold the occupancy code. The code is 0 for zero or one stored character, and 1, 2 or 3 for two, three or four stored characters.
- R3: After reset the status byte reads 0x00.
- R4: A frame whose stop bit is sampled low sets the framing flag, status bit 2.
- R5: When `par_en` is 1, the parity bit is checked as the character enters the buffer. `par_odd`=0 expects an even count of ones over the data and parity bits, and `par_odd`=1 expects an odd count. A mismatch sets the parity flag, status bit 3. When `par_en` is 0 no parity bit is expected.
- R6: The flags are sticky. A status write clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1. Status bits [7:5] read 0.
- R7: A character that completes while all four entries are full is discarded, and the overrun flag (status bit 4) is set.
- R8: A read strobe at address 0 pops the oldest character. A read of an empty buffer returns the last character read and leaves the occupancy unchanged.
- R9: A start bit is accepted only if the line is still low at mid start bit. A shorter low pulse stores nothing.
- R10: Data bits are assembled least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input; idles high |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| reg_addr | input | 1 | 0: data register, 1: status register |
| reg_wr | input | 1 | Write strobe (status register only) |
| reg_rd | input | 1 | Read strobe; at address 0 it pops the buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address |

## Verification
A fault in the deframer's bit counter or sample timing shows up at the port as wrong character values or a raised framing flag. Both are visible at the status and data registers within a few cycles of the stop bit. A fault in the buffer pointers or the occupancy counter shows up as a wrong occupancy code or characters out of order on the next reads. A flag that fails to set, fails to hold or clears on the wrong write value is visible on the very next status read. A false start that is taken as a real one leaves an extra entry, which raises the occupancy code once further frames arrive.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_bit;
        logic       has_par;
        logic       stop_ok;
    } rx_frame_t;
endpackage

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_i,
    input  logic      tick_i,
    input  logic      par_en_i,
    output rx_frame_t frame_o,
    output logic      valid_o
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DW);
    localparam int HALF = OVS / 2;

    rx_state_t       state_q, state_d;
    logic [1:0]      sync_q;
    logic            rx_s;
    logic [CW-1:0]   tcnt_q;
    logic [BW-1:0]   bit_q;
    logic [DW-1:0]   shreg_q;
    logic            par_q, has_par_q, stop_q, valid_q;
    logic            bit_end, half_end;

    assign rx_s     = sync_q[1];
    assign bit_end  = tick_i && (tcnt_q == CW'(OVS - 1));
    assign half_end = tick_i && (tcnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (!rx_s) state_d = S_START;
            S_START: if (half_end) state_d = rx_s ? S_IDLE : S_DATA;
            S_DATA:  if (bit_end && bit_q == BW'(DW - 1))
                         state_d = par_en_i ? S_PAR : S_STOP;
            S_PAR:   if (bit_end) state_d = S_STOP;
            S_STOP:  if (bit_end) state_d = rx_s ? S_IDLE : S_HOLD;
            S_HOLD:  if (rx_s) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q    <= '0;
            bit_q     <= '0;
            shreg_q   <= '0;
            par_q     <= 1'b0;
            has_par_q <= 1'b0;
            stop_q    <= 1'b1;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (state_q == S_IDLE || state_q == S_HOLD) begin
                tcnt_q <= '0;
            end else if (tick_i) begin
                if ((state_q == S_START && half_end) || bit_end) tcnt_q <= '0;
                else                                             tcnt_q <= tcnt_q + 1'b1;
            end
            unique case (state_q)
                S_START: begin
                    bit_q     <= '0;
                    has_par_q <= 1'b0;
                end
                S_DATA: if (bit_end) begin
                    shreg_q <= {rx_s, shreg_q[DW-1:1]};
                    bit_q   <= bit_q + 1'b1;
                end
                S_PAR: if (bit_end) begin
                    par_q     <= rx_s;
                    has_par_q <= 1'b1;
                end
                S_STOP: if (bit_end) begin
                    stop_q  <= rx_s;
                    valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign valid_o         = valid_q;
    assign frame_o.data    = shreg_q[7:0];
    assign frame_o.par_bit = par_q;
    assign frame_o.has_par = has_par_q;
    assign frame_o.stop_ok = stop_q;

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    a_r9_no_frame_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !valid_q);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int OW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [OW-1:0] occ_q;
    logic          do_push, do_pop;

    assign full    = (occ_q == OW'(DEPTH));
    assign empty   = (occ_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            occ_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            if (do_push && !do_pop)      occ_q <= occ_q + 1'b1;
            else if (do_pop && !do_push) occ_q <= occ_q - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mem_q[i] <= '0;
            else if (do_push && wp_q == PW'(i))       mem_q[i] <= din;
        end
    end

    assign dout = mem_q[rp_q];
    assign occ  = occ_q;

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(DEPTH));
    a_r1_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (occ_q == $past(occ_q) + 1'b1));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import srx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       baud_tick,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    localparam int OW     = $clog2(DEPTH + 1);
    localparam int CODEW  = $clog2(DEPTH);
    localparam int FE_BIT = CODEW;
    localparam int PE_BIT = CODEW + 1;
    localparam int OE_BIT = CODEW + 2;

    rx_frame_t      frm;
    logic           frm_valid;
    logic [7:0]     head, last_q;
    logic [OW-1:0]  occ;
    logic           full, empty;
    logic           pop_req, pop_ok, room, push_ok;
    logic           stat_wr, ferr_q, perr_q, oerr_q;
    logic           par_bad;
    logic [CODEW-1:0] code;
    logic [7:0]     status;

    srx_deframer #(.OVS(OVS), .DW(8)) u_deframer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_i    (rx_line),
        .tick_i  (baud_tick),
        .par_en_i(par_en),
        .frame_o (frm),
        .valid_o (frm_valid)
    );

    srx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push_ok),
        .pop  (pop_ok),
        .din  (frm.data),
        .dout (head),
        .occ  (occ),
        .full (full),
        .empty(empty)
    );

    assign pop_req = reg_rd && !reg_addr;
    assign pop_ok  = pop_req && !empty;
    assign room    = !full || pop_ok;
    assign push_ok = frm_valid && room;
    assign stat_wr = reg_wr && reg_addr;
    assign par_bad = frm.has_par && ((^{frm.data, frm.par_bit}) != par_odd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            perr_q <= 1'b0;
            oerr_q <= 1'b0;
            last_q <= '0;
        end else begin
            if (frm_valid && !frm.stop_ok)      ferr_q <= 1'b1;
            else if (stat_wr && !reg_wdata[FE_BIT]) ferr_q <= 1'b0;
            if (push_ok && par_bad)             perr_q <= 1'b1;
            else if (stat_wr && !reg_wdata[PE_BIT]) perr_q <= 1'b0;
            if (frm_valid && !room)             oerr_q <= 1'b1;
            else if (stat_wr && !reg_wdata[OE_BIT]) oerr_q <= 1'b0;
            if (pop_ok) last_q <= head;
        end
    end

    assign code      = (occ <= OW'(1)) ? '0 : CODEW'(occ - OW'(1));
    assign status    = 8'({oerr_q, perr_q, ferr_q, code});
    assign reg_rdata = reg_addr ? status : (empty ? last_q : head);

    a_r6_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !(stat_wr && !reg_wdata[FE_BIT])) |=> ferr_q);
    a_r6_oerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr_q && !(stat_wr && !reg_wdata[OE_BIT])) |=> oerr_q);
    a_r4_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm.stop_ok) |=> ferr_q);
    a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && full && !pop_req) |=> (oerr_q && full));
    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !frm_valid) |=> (empty && $stable(reg_rdata)));
endmodule

// File: tb/test_serial_rx_status.sv
`timescale 1ns/1ps
module test_serial_rx_status;
    localparam int OVS = 16;
    localparam int BIT = OVS * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0;
    logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] tdiv;
    logic       baud_tick;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 1'b1;
    end
    assign baud_tick = &tdiv;

    serial_rx_status #(.OVS(OVS), .DEPTH(4)) i_serial_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .par_en(par_en), .par_odd(par_odd), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int cycles);
        rx_line = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic with_par,
                        input logic pbit, input logic stop);
        @(negedge clk);
        hold_line(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold_line(d[i], BIT);
        if (with_par) hold_line(pbit, BIT);
        hold_line(stop, BIT);
        hold_line(1'b1, 2 * BIT);
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 1'b1;
        #1 v = reg_rdata;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 1'b0;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_status(input logic [7:0] v);
        @(negedge clk);
        reg_addr  = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_status(v);
        chk(v, 8'h00, "R3 status after reset");
    endtask

    task automatic t_single;
        logic [7:0] v;
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h00, "R2 one entry code 0");
        rd_data(v);   chk(v, 8'hA5, "R10 lsb-first byte");
        rd_data(v);   chk(v, 8'hA5, "R8 empty read repeats last");
        rd_status(v); chk(v, 8'h00, "R8 empty read keeps count");
    endtask

    task automatic t_fill;
        logic [7:0] v;
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h01, "R2 two entries code 1");
        send(8'h33, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h02, "R2 three entries code 2");
        send(8'h44, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h03, "R2 four entries code 3");
        send(8'h55, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h13, "R7 overrun flag with full buffer");
        rd_data(v); chk(v, 8'h11, "R1 order entry 0");
        rd_data(v); chk(v, 8'h22, "R1 order entry 1");
        rd_data(v); chk(v, 8'h33, "R1 order entry 2");
        rd_data(v); chk(v, 8'h44, "R7 fifth char discarded");
        rd_data(v); chk(v, 8'h44, "R8 empty read after drain");
        rd_status(v); chk(v, 8'h10, "R6 overrun stays set");
        wr_status(8'hFF);
        rd_status(v); chk(v, 8'h10, "R6 write 1 has no effect");
        wr_status(8'h00);
        rd_status(v); chk(v, 8'h00, "R6 write 0 clears");
    endtask

    task automatic t_framing;
        logic [7:0] v;
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        rd_status(v); chk(v, 8'h04, "R4 framing flag");
        rd_data(v);   chk(v, 8'h3C, "R4 data kept");
        wr_status(8'hFB);
        rd_status(v); chk(v, 8'h00, "R6 clear framing only by 0");
    endtask

    task automatic t_parity;
        logic [7:0] v;
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h07, 1'b1, 1'b1, 1'b1);
        rd_status(v); chk(v, 8'h00, "R5 even parity ok");
        rd_data(v);   chk(v, 8'h07, "R5 data with parity");
        send(8'h07, 1'b1, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h08, "R5 even parity error");
        rd_data(v);
        wr_status(8'h00);
        par_odd = 1'b1;
        send(8'h07, 1'b1, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h00, "R5 odd parity ok");
        rd_data(v);
        send(8'h07, 1'b1, 1'b1, 1'b1);
        rd_status(v); chk(v, 8'h08, "R5 odd parity error");
        rd_data(v);
        wr_status(8'h00);
        par_en = 1'b0; par_odd = 1'b0;
        send(8'h81, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h00, "R5 disabled no flag");
        rd_data(v);   chk(v, 8'h81, "R5 disabled data");
    endtask

    task automatic t_glitch;
        logic [7:0] v;
        @(negedge clk);
        hold_line(1'b0, 12);
        hold_line(1'b1, 3 * BIT);
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        send(8'hC3, 1'b0, 1'b0, 1'b1);
        rd_status(v); chk(v, 8'h01, "R9 false start stores nothing");
        rd_data(v);   chk(v, 8'h5A, "R9 first real char");
        rd_data(v);   chk(v, 8'hC3, "R9 second real char");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_single;
        t_fill;
        t_framing;
        t_parity;
        t_glitch;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule